// File: doc/BRIEF.md
# External Reset Pin Sequencer

This block controls a shared, open-drain reset line from the synchronous side of a chip. Any reset cause (power-up, a request from inside the chip, or another device pulling the line low) becomes one fixed-length low pulse on the line. After the pulse the driver lets go and waits a short settle time, then reads the line through a synchronizer. If something outside still holds the line low, the block pulls it low for another full pulse and tries again. It keeps doing this until the line reads high, and then it issues a one-cycle start pulse for the reset exception.

On power-up the line stays driven until the PLL has reported lock for a fixed number of cycles. A short module-reset pulse goes to on-chip logic each time a new sequence begins. A three-state control input, held high while a reset sequence is active, can latch a lockout. The lockout turns off the line driver and raises a global output-disable, and only a new power-on clears it.

Top module: `rstpin_sequencer`

## Requirements
- R1: Every drive phase holds `pin_drive_en` high for exactly DRIVE_CYCLES (default 512) consecutive cycles.
- R2: After each drive phase (and after the power-on hold), `pin_drive_en` stays low for exactly SETTLE_CYCLES (default 10) cycles. At the last of these edges the block reads the line level as seen through a SYNC_STAGES (default 2) flop synchronizer.
- R3: If that read gives 1, `exc_start` is high for exactly one cycle, in the cycle after the release window, and the block goes idle with `pin_drive_en` low.
- R4: If that read gives 0, a new drive phase starts in the cycle after the release window. Drive and release alternate with no limit on the number of attempts.
- R5: While `por` is 1, `pin_drive_en` is 1. After `por` falls, the line stays driven until `pll_lock` has been 1 at PLL_HOLD_CYCLES (default 512) consecutive rising edges, and any edge with `pll_lock` at 0 restarts that count. The release of R2 then follows.
- R6: From idle, `int_rst_req` at 1 on a rising edge starts a drive phase, with `pin_drive_en` high in the cycle after that edge. A low level on `pin_in` also starts a drive phase; with 2 synchronizer stages, `pin_drive_en` is high in the third cycle after the line goes low.
- R7: `mod_rst` is high for exactly MOD_RST_CYCLES (default 4) cycles from the cycle in which a new sequence starts from idle. At power-on it is high while `por` is 1 and for MOD_RST_CYCLES-1 cycles after `por` falls.
- R8: An `int_rst_req` that arrives while a sequence is running (in any state other than idle) is ignored. The drive phase still lasts DRIVE_CYCLES, and `mod_rst` is not pulsed again.
- R9: If `tsc_in` is 1 while a sequence is running, for TSC_HOLD_CYCLES (default 10) consecutive edges, `out_disable` rises in the cycle after the last of those edges. In that same cycle `pin_drive_en` and `exc_start` are forced to 0. A shorter run restarts the count. `tsc_in` while idle is ignored.
- R10: Once `out_disable` is 1 it stays 1, with `pin_drive_en` and `exc_start` held at 0 whatever the inputs do, until `por` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, active high, synchronous; also the block's own reset |
| pll_lock | input | 1 | PLL lock indication |
| int_rst_req | input | 1 | Reset request from inside the chip |
| pin_in | input | 1 | Raw level read back from the reset line |
| tsc_in | input | 1 | Three-state control request |
| pin_drive_en | output | 1 | 1 = pull the reset line low; 0 = release the line (high impedance) |
| mod_rst | output | 1 | Reset to on-chip modules |
| exc_start | output | 1 | One-cycle pulse that starts reset exception processing |
| out_disable | output | 1 | Latched global output-disable (three-state lockout) |

## Verification
Every result is due a fixed number of cycles after its cause. A drive from `int_rst_req` starts in the next cycle, and a drive from the line starts SYNC_STAGES+1 cycles after the line goes low. Release begins DRIVE_CYCLES cycles after the drive starts, and `exc_start` or the next drive follows SETTLE_CYCLES cycles after that. `out_disable` rises TSC_HOLD_CYCLES cycles after `tsc_in` rises. The bench drives the inputs and reads the outputs on falling clock edges. It counts those edges between cause and effect and compares each count with the value that its functions derive from the parameters. The open-drain line is modelled as the wired combination of the block's driver and an external holder, whose release point is chosen at random.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

  typedef enum logic [1:0] {
    ST_POWERUP = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_SETTLE  = 2'd2,
    ST_IDLE    = 2'd3
  } seq_state_t;

  function automatic int cnt_width(input int max_count);
    return (max_count > 1) ? $clog2(max_count) : 1;
  endfunction

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq
  import rstpin_pkg::*;
#(
  parameter int DRIVE_CYCLES    = 512,
  parameter int SETTLE_CYCLES   = 10,
  parameter int PLL_HOLD_CYCLES = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_lock,
  input  logic req,
  input  logic line_hi,
  output logic busy,
  output logic start,
  output logic drive_nx,
  output logic exc_nx
);

  localparam int MAXC = (DRIVE_CYCLES > PLL_HOLD_CYCLES) ?
                        ((DRIVE_CYCLES > SETTLE_CYCLES) ? DRIVE_CYCLES : SETTLE_CYCLES) :
                        ((PLL_HOLD_CYCLES > SETTLE_CYCLES) ? PLL_HOLD_CYCLES : SETTLE_CYCLES);
  localparam int CW = cnt_width(MAXC);
  localparam logic [CW-1:0] DRV_LAST = CW'(DRIVE_CYCLES - 1);
  localparam logic [CW-1:0] STL_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] PLL_LAST = CW'(PLL_HOLD_CYCLES - 1);

  seq_state_t      state_q, state_n;
  logic [CW-1:0]   cnt_q, cnt_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    start   = 1'b0;
    exc_nx  = 1'b0;
    unique case (state_q)
      ST_POWERUP: begin
        if (!pll_lock) begin
          cnt_n = '0;
        end else if (cnt_q == PLL_LAST) begin
          state_n = ST_SETTLE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      ST_DRIVE: begin
        if (cnt_q == DRV_LAST) begin
          state_n = ST_SETTLE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      ST_SETTLE: begin
        if (cnt_q == STL_LAST) begin
          cnt_n = '0;
          if (line_hi) begin
            state_n = ST_IDLE;
            exc_nx  = 1'b1;
          end else begin
            state_n = ST_DRIVE;
          end
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      default: begin
        if (req || !line_hi) begin
          state_n = ST_DRIVE;
          cnt_n   = '0;
          start   = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_POWERUP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  assign drive_nx = (state_n == ST_POWERUP) || (state_n == ST_DRIVE);
  assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/rstpin_stretch.sv
module rstpin_stretch #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);

  localparam int LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LOAD = LW'(LEN);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || start)        left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - LW'(1);
  end

  assign active = (left_q != '0);

endmodule

// File: rtl/rstpin_tsc.sv
module rstpin_tsc
  import rstpin_pkg::*;
#(
  parameter int HOLD_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tsc,
  input  logic busy,
  output logic lock_nx,
  output logic lock_q
);

  localparam int TW = cnt_width(HOLD_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(HOLD_CYCLES - 1);

  logic [TW-1:0] run_q, run_n;

  always_comb begin
    lock_nx = lock_q;
    run_n   = '0;
    if (!lock_q && tsc && busy) begin
      if (run_q == LAST) lock_nx = 1'b1;
      else               run_n   = run_q + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      lock_q <= lock_nx;
    end
  end

endmodule

// File: rtl/rstpin_sequencer.sv
module rstpin_sequencer #(
  parameter int DRIVE_CYCLES    = 512,
  parameter int SETTLE_CYCLES   = 10,
  parameter int PLL_HOLD_CYCLES = 512,
  parameter int MOD_RST_CYCLES  = 4,
  parameter int TSC_HOLD_CYCLES = 10,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic por,
  input  logic pll_lock,
  input  logic int_rst_req,
  input  logic pin_in,
  input  logic tsc_in,
  output logic pin_drive_en,
  output logic mod_rst,
  output logic exc_start,
  output logic out_disable
);

  logic line_hi;
  logic busy;
  logic start;
  logic drive_nx;
  logic exc_nx;
  logic lock_nx;

  rstpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (por),
    .d   (pin_in),
    .q   (line_hi)
  );

  rstpin_seq #(
    .DRIVE_CYCLES    (DRIVE_CYCLES),
    .SETTLE_CYCLES   (SETTLE_CYCLES),
    .PLL_HOLD_CYCLES (PLL_HOLD_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst      (por),
    .pll_lock (pll_lock),
    .req      (int_rst_req),
    .line_hi  (line_hi),
    .busy     (busy),
    .start    (start),
    .drive_nx (drive_nx),
    .exc_nx   (exc_nx)
  );

  rstpin_stretch #(.LEN(MOD_RST_CYCLES)) u_modrst (
    .clk    (clk),
    .rst    (por),
    .start  (start),
    .active (mod_rst)
  );

  rstpin_tsc #(.HOLD_CYCLES(TSC_HOLD_CYCLES)) u_tsc (
    .clk     (clk),
    .rst     (por),
    .tsc     (tsc_in),
    .busy    (busy),
    .lock_nx (lock_nx),
    .lock_q  (out_disable)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      pin_drive_en <= 1'b1;
      exc_start    <= 1'b0;
    end else begin
      pin_drive_en <= drive_nx & ~lock_nx;
      exc_start    <= exc_nx & ~lock_nx;
    end
  end

endmodule

// File: rtl/rstpin_sequencer_chk.sv
module rstpin_sequencer_chk #(
  parameter int DRIVE_CYCLES    = 512,
  parameter int SETTLE_CYCLES   = 10,
  parameter int PLL_HOLD_CYCLES = 512,
  parameter int MOD_RST_CYCLES  = 4
) (
  input logic clk,
  input logic por,
  input logic pin_drive_en,
  input logic mod_rst,
  input logic exc_start,
  input logic out_disable
);

  localparam int MIN_DRV = (DRIVE_CYCLES < PLL_HOLD_CYCLES) ? DRIVE_CYCLES : PLL_HOLD_CYCLES;

  logic [15:0] drv_run, rel_run, mr_run;

  always_ff @(posedge clk) begin
    if (por) begin
      drv_run <= 16'd1;
      rel_run <= '0;
      mr_run  <= 16'd1;
    end else begin
      drv_run <= pin_drive_en  ? ((drv_run != '1) ? drv_run + 16'd1 : drv_run) : '0;
      rel_run <= !pin_drive_en ? ((rel_run != '1) ? rel_run + 16'd1 : rel_run) : '0;
      mr_run  <= mod_rst       ? ((mr_run  != '1) ? mr_run  + 16'd1 : mr_run)  : '0;
    end
  end

  p_drive_min_r1: assert property (@(posedge clk) disable iff (por)
    ($fell(pin_drive_en) && !out_disable) |-> (drv_run >= 16'(MIN_DRV)));

  p_release_min_r2: assert property (@(posedge clk) disable iff (por)
    $rose(pin_drive_en) |-> (rel_run >= 16'(SETTLE_CYCLES)));

  p_exc_after_release_r3: assert property (@(posedge clk) disable iff (por)
    exc_start |-> (!pin_drive_en && rel_run >= 16'(SETTLE_CYCLES)));

  p_exc_single_r3: assert property (@(posedge clk) disable iff (por)
    exc_start |=> !exc_start);

  p_modrst_len_r7: assert property (@(posedge clk) disable iff (por)
    $fell(mod_rst) |-> (mr_run >= 16'(MOD_RST_CYCLES)));

  p_lock_quiet_r10: assert property (@(posedge clk) disable iff (por)
    out_disable |-> (!pin_drive_en && !exc_start));

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (por)
    out_disable |=> out_disable);

endmodule

bind rstpin_sequencer rstpin_sequencer_chk #(
  .DRIVE_CYCLES    (DRIVE_CYCLES),
  .SETTLE_CYCLES   (SETTLE_CYCLES),
  .PLL_HOLD_CYCLES (PLL_HOLD_CYCLES),
  .MOD_RST_CYCLES  (MOD_RST_CYCLES)
) u_chk (
  .clk          (clk),
  .por          (por),
  .pin_drive_en (pin_drive_en),
  .mod_rst      (mod_rst),
  .exc_start    (exc_start),
  .out_disable  (out_disable)
);

// File: tb/test_rstpin_sequencer.sv
module test_rstpin_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int DRV  = 512;
  localparam int STL  = 10;
  localparam int HOLD = 512;
  localparam int MODR = 4;
  localparam int TSCN = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic por, pll_lock, int_rst_req, tsc_in, ext_low;
  logic pin_in;
  logic pin_drive_en, mod_rst, exc_start, out_disable;
  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pin_in = !(pin_drive_en || ext_low);

  rstpin_sequencer #(
    .DRIVE_CYCLES(DRV), .SETTLE_CYCLES(STL), .PLL_HOLD_CYCLES(HOLD),
    .MOD_RST_CYCLES(MODR), .TSC_HOLD_CYCLES(TSCN), .SYNC_STAGES(SYNC)
  ) i_rstpin_sequencer (
    .clk(clk), .por(por), .pll_lock(pll_lock), .int_rst_req(int_rst_req),
    .pin_in(pin_in), .tsc_in(tsc_in), .pin_drive_en(pin_drive_en),
    .mod_rst(mod_rst), .exc_start(exc_start), .out_disable(out_disable)
  );

  function automatic int exp_trigger_delay(input bit by_line);
    return by_line ? SYNC + 1 : 1;
  endfunction

  function automatic int exp_modrst_after_por();
    return MODR - 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_release(output int m);
    m = 0;
    while (!pin_drive_en && !exc_start && m < 4000) begin
      @(negedge clk); m++;
    end
  endtask

  task automatic do_por(input int lock_delay, input bit drop);
    int n, mr, held, m;
    por = 1'b1; pll_lock = 1'b0; ext_low = 1'b0; tsc_in = 1'b0; int_rst_req = 1'b0;
    repeat (3) @(negedge clk);
    check(pin_drive_en == 1'b1, "R5 drive during por", pin_drive_en, 1);
    check(mod_rst == 1'b1, "R7 mod_rst during por", mod_rst, 1);
    check(exc_start == 1'b0, "R3 no exc during por", exc_start, 0);
    check(out_disable == 1'b0, "R10 por clears lockout", out_disable, 0);
    por = 1'b0;
    mr = 0; held = 0;
    for (int i = 0; i < lock_delay; i++) begin
      @(negedge clk);
      if (mod_rst) mr++;
      if (pin_drive_en) held++;
    end
    check(mr == exp_modrst_after_por(), "R7 mod_rst after por", mr, exp_modrst_after_por());
    check(held == lock_delay, "R5 held without lock", held, lock_delay);
    pll_lock = 1'b1;
    if (drop) begin
      repeat (100) @(negedge clk);
      pll_lock = 1'b0;
      repeat (5) @(negedge clk);
      pll_lock = 1'b1;
    end
    n = 0;
    do begin @(negedge clk); n++; end while (pin_drive_en && n < 4000);
    check(n == HOLD, "R5 hold after lock", n, HOLD);
    measure_release(m);
    check(m == STL, "R2 release after power-up", m, STL);
    check(exc_start == 1'b1, "R3 exc after power-up", exc_start, 1);
    @(negedge clk);
    check(exc_start == 1'b0 && pin_drive_en == 1'b0, "R3 single pulse then idle", exc_start, 0);
  endtask

  task automatic run_seq(input int retries, input bit use_pin, input bit absorb);
    int n, m, mr, wait_n, exp_d;
    if (use_pin) ext_low = 1'b1;
    else         int_rst_req = 1'b1;
    if (retries > 0) ext_low = 1'b1;
    wait_n = 0;
    do begin @(negedge clk); int_rst_req = 1'b0; wait_n++; end
    while (!pin_drive_en && wait_n < 8);
    exp_d = exp_trigger_delay(use_pin);
    check(wait_n == exp_d, "R6 trigger delay", wait_n, exp_d);
    for (int p = 0; p <= retries; p++) begin
      n = 0; mr = 0;
      while (pin_drive_en && n < 4000) begin
        if (mod_rst) mr++;
        if (p == retries && n == 100) ext_low = 1'b0;
        int_rst_req = (absorb && p == 0 && n == 37);
        @(negedge clk); n++;
      end
      int_rst_req = 1'b0;
      check(n == DRV, absorb ? "R8 drive length with absorbed request" : "R1 drive length", n, DRV);
      if (p == 0) check(mr == MODR, absorb ? "R8 mod_rst not reloaded" : "R7 mod_rst pulse", mr, MODR);
      measure_release(m);
      check(m == STL, "R2 release length", m, STL);
      if (p < retries) begin
        check(pin_drive_en == 1'b1 && exc_start == 1'b0, "R4 retry after low read", pin_drive_en, 1);
      end else begin
        check(exc_start == 1'b1, "R3 exc after high read", exc_start, 1);
        @(negedge clk);
        check(exc_start == 1'b0 && pin_drive_en == 1'b0, "R3 single pulse then idle", exc_start, 0);
      end
    end
  endtask

  initial begin
    int n, seen;
    void'($urandom(32'h1a2b3c4d));
    por = 1'b1; pll_lock = 1'b0; int_rst_req = 1'b0; tsc_in = 1'b0; ext_low = 1'b0;

    do_por(20, 1'b0);

    seen = 0;
    repeat (50) begin @(negedge clk); if (pin_drive_en || exc_start) seen++; end
    check(seen == 0, "R3 idle stays quiet", seen, 0);

    run_seq(0, 1'b0, 1'b0);
    run_seq(2, 1'b1, 1'b0);
    run_seq(0, 1'b0, 1'b1);

    tsc_in = 1'b1;
    repeat (3 * TSCN) @(negedge clk);
    tsc_in = 1'b0;
    check(out_disable == 1'b0, "R9 tsc ignored while idle", out_disable, 0);
    @(negedge clk);

    for (int k = 0; k < 10; k++) begin
      repeat ($urandom_range(5, 40)) @(negedge clk);
      run_seq($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    int_rst_req = 1'b1;
    @(negedge clk);
    int_rst_req = 1'b0;
    repeat (5) @(negedge clk);
    tsc_in = 1'b1;
    repeat (TSCN - 1) @(negedge clk);
    tsc_in = 1'b0;
    check(out_disable == 1'b0 && pin_drive_en == 1'b1, "R9 short tsc run does not latch", out_disable, 0);
    @(negedge clk);
    tsc_in = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!out_disable && n < 50);
    tsc_in = 1'b0;
    check(n == TSCN, "R9 tsc latch delay", n, TSCN);
    check(pin_drive_en == 1'b0, "R9 driver forced off", pin_drive_en, 0);

    seen = 0;
    for (int i = 0; i < 1500; i++) begin
      int_rst_req = (i % 300 == 7);
      ext_low = (i > 800 && i < 805);
      @(negedge clk);
      if (!out_disable || pin_drive_en || exc_start) seen++;
    end
    int_rst_req = 1'b0; ext_low = 1'b0;
    check(seen == 0, "R10 lockout sticky and quiet", seen, 0);

    do_por(15, 1'b1);
    run_seq(1, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule